// File: doc/BRIEF.md
# Octal Scan Latch Test Registers

This block wraps an eight-channel transparent latch with the test data registers a boundary-scan port needs: an 18-cell boundary register, a 2-bit self-test control register and a single bypass cell. A separate TAP controller supplies a register select, capture, shift and update strobes, and an idle indicator. The block returns the serial output of the selected register on `tdo_o`.

With `test_mode_i` low the pins behave as an ordinary octal latch with an active-low output enable. Scanning and self-test keep running underneath but never reach the pins. With `test_mode_i` high, the output-side hold stages of the boundary register drive the data outputs and the enable. The boundary register can also sample the pins at any time.

While the controller idles, the control code picks one of two self-test modes. One compresses the eight data inputs into the output hold stages as a signature. The other steps those stages as a free-running pseudo-random pattern source. The feedback polynomial is x^8+x^6+x^5+x^4+1.

Top module: `octal_scan_latch`

## Requirements
- R1: With `test_mode_i`=0, `q_drive_o` equals the inverse of `oe_n_i`, whatever the latch state.
- R2: With `test_mode_i`=0 and `le_i`=1, `q_o` equals `d_i` in the same cycle. With `le_i`=0, `q_o` keeps the `d_i` value sampled at the last clock edge at which `le_i` was 1 (0 after reset).
- R3: Boundary cell map, bit 0 nearest `tdo_o`: bits 0..7 are `d_i[0..7]`, bit 8 is `oe_n_i`, bit 9 is `le_i`, bits 10..17 are `q_o[0..7]`. With `dr_sel_i`=01, a clock edge with `capture_i`=1 loads these pin values into the shift stage, and `tdo_o` shows shift bit 0.
- R4: With `dr_sel_i`=01 and `shift_i`=1, each edge moves the shift stage one place toward bit 0 and loads `tdi_i` into bit 17.
- R5: With `dr_sel_i`=01, an edge with `update_i`=1 copies the shift stage into the hold stage. With `test_mode_i`=1, `q_o` is hold bits 17..10 and `q_drive_o` is the inverse of hold bit 8.
- R6: With `dr_sel_i`=10 the 2-bit control register is selected. Capture loads the active code into its shift stage, shift loads `tdi_i` into bit 1 with `tdo_o` showing bit 0, and update makes the shift value the active code.
- R7: With `dr_sel_i`=00 or 11 the bypass cell is selected. Capture clears it, shift loads `tdi_i`, and `tdo_o` shows it.
- R8: Active code 10 (signature mode): each edge with `idle_i`=1 replaces output hold bits s=hold[17:10] with {s[6:0], s[7]^s[5]^s[4]^s[3]} XOR `d_i`.
- R9: Active code 01 (pattern mode) applies the same step without `d_i`. Codes 00 and 11 leave the hold stage unchanged while idle.
- R10: With `idle_i`=0 and no boundary update, the hold stage does not change, whatever the active code.
- R11: In normal mode, boundary scans, updates and self-test steps leave `q_o` and `q_drive_o` following R1 and R2 only.
- R12: After reset all shift stages and the bypass cell are 0, the hold stage is 0 except bit 8 = 1 (outputs disabled in test mode), the latch holds 0, and the active code is 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset, held low while the controller resets the test logic |
| test_mode_i | input | 1 | 1: boundary hold stages own the outputs |
| dr_sel_i | input | 2 | Data register select: 00 bypass, 01 boundary, 10 control, 11 bypass |
| capture_i | input | 1 | Capture strobe for the selected register |
| shift_i | input | 1 | Shift strobe for the selected register |
| update_i | input | 1 | Update strobe for the selected register |
| idle_i | input | 1 | Controller is in Run-Test/Idle |
| tdi_i | input | 1 | Serial test data in |
| tdo_o | output | 1 | Serial test data out of the selected register |
| d_i | input | 8 | Latch data inputs |
| oe_n_i | input | 1 | Active-low output enable |
| le_i | input | 1 | Latch enable, transparent when 1 |
| q_o | output | 8 | Data outputs |
| q_drive_o | output | 1 | 1 when the outputs are driven, 0 for high impedance |

## Verification
The bench aims at the handover between latch-through and latch-hold, at captures of output cells while test mode drives them, and at shifting exactly eighteen or two bits so that an off-by-one cell order or a reversed shift direction shows up as a misplaced bit on `tdo_o`. It runs both self-test modes from a nonzero seed and then parks in the two no-operation codes and in non-idle cycles. A wrong tap set, a dropped input XOR or a self-test that runs outside idle would make the output pattern diverge within a few steps. Scanning and idling in normal mode catch any leak of test state onto the pins.

// File: rtl/bscan_pkg.sv
`timescale 1ns/1ps
package bscan_pkg;
    typedef enum logic [1:0] {
        DR_BYPASS = 2'b00,
        DR_BOUND  = 2'b01,
        DR_CTRL   = 2'b10,
        DR_SPARE  = 2'b11
    } dr_sel_e;

    typedef enum logic [1:0] {
        BIST_OFF_A = 2'b00,
        BIST_PRPG  = 2'b01,
        BIST_PSA   = 2'b10,
        BIST_OFF_B = 2'b11
    } bist_code_e;

    localparam logic [1:0] BIST_RESET_CODE = 2'b10;
endpackage

// File: rtl/bscan_lfsr.sv
`timescale 1ns/1ps
module bscan_lfsr #(
    parameter int          W    = 8,
    parameter logic [W-1:0] TAPS = 8'hB8
) (
    input  logic [W-1:0] state_i,
    input  logic [W-1:0] data_i,
    input  logic         compress_i,
    output logic [W-1:0] next_o
);
    logic fb;

    always_comb begin
        fb     = ^(state_i & TAPS);
        next_o = {state_i[W-2:0], fb} ^ (compress_i ? data_i : '0);
    end
endmodule

// File: rtl/bscan_bsr.sv
`timescale 1ns/1ps
module bscan_bsr #(
    parameter int          N    = 8,
    parameter logic [N-1:0] TAPS = 8'hB8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_en,
    input  logic         shift_en,
    input  logic         upd_en,
    input  logic         bist_run,
    input  logic         psa_mode,
    input  logic         tdi,
    input  logic [N-1:0] pin_d,
    input  logic         pin_oe_n,
    input  logic         pin_le,
    input  logic [N-1:0] pin_q,
    output logic         scan_lsb,
    output logic [N-1:0] q_hold_o,
    output logic         oe_hold_o
);
    localparam int W      = 2 * N + 2;
    localparam int OE_BIT = N;
    localparam int Q_LO   = N + 2;
    localparam logic [W-1:0] HOLD_RST = W'(1) << OE_BIT;

    typedef struct packed {
        logic [W-1:0] sh;
        logic [W-1:0] hold;
    } bsr_st_t;

    bsr_st_t      st_d, st_q;
    logic [N-1:0] lfsr_next;

    bscan_lfsr #(.W(N), .TAPS(TAPS)) u_lfsr (
        .state_i   (st_q.hold[W-1:Q_LO]),
        .data_i    (pin_d),
        .compress_i(psa_mode),
        .next_o    (lfsr_next)
    );

    always_comb begin
        st_d = st_q;
        if (cap_en) begin
            st_d.sh = {pin_q, pin_le, pin_oe_n, pin_d};
        end else if (shift_en) begin
            st_d.sh = {tdi, st_q.sh[W-1:1]};
        end
        if (upd_en) begin
            st_d.hold = st_q.sh;
        end else if (bist_run) begin
            st_d.hold[W-1:Q_LO] = lfsr_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sh   <= '0;
            st_q.hold <= HOLD_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign scan_lsb  = st_q.sh[0];
    assign q_hold_o  = st_q.hold[W-1:Q_LO];
    assign oe_hold_o = st_q.hold[OE_BIT];

    // R3: input cells take the pin values on capture
    p_capture_inputs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> st_q.sh[N-1:0] == $past(pin_d));

    // R4: shift moves toward bit 0 and feeds tdi at the top
    p_shift_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !cap_en) |=> st_q.sh == {$past(tdi), $past(st_q.sh[W-1:1])});

    // R10: hold stage only moves on update or self-test
    p_hold_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en && !bist_run) |=> $stable(st_q.hold));

    // R8: self-test never touches the input-side hold cells
    p_bist_scope_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bist_run && !upd_en) |=> $stable(st_q.hold[Q_LO-1:0]));
endmodule

// File: rtl/bscan_ctl.sv
`timescale 1ns/1ps
module bscan_ctl
    import bscan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bcr_cap,
    input  logic       bcr_shift,
    input  logic       bcr_upd,
    input  logic       byp_cap,
    input  logic       byp_shift,
    input  logic       tdi,
    output logic [1:0] code_o,
    output logic       bcr_lsb,
    output logic       byp_o
);
    typedef struct packed {
        logic [1:0] sh;
        logic [1:0] code;
        logic       byp;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bcr_cap) begin
            st_d.sh = st_q.code;
        end else if (bcr_shift) begin
            st_d.sh = {tdi, st_q.sh[1]};
        end
        if (bcr_upd) begin
            st_d.code = st_q.sh;
        end
        if (byp_cap) begin
            st_d.byp = 1'b0;
        end else if (byp_shift) begin
            st_d.byp = tdi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sh   <= '0;
            st_q.code <= BIST_RESET_CODE;
            st_q.byp  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o  = st_q.code;
    assign bcr_lsb = st_q.sh[0];
    assign byp_o   = st_q.byp;

    // R6: the active code moves only on an update
    p_code_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bcr_upd |=> $stable(st_q.code));

    // R7: bypass captures a zero
    p_byp_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        byp_cap |=> !st_q.byp);

    // R7: bypass delays tdi by one stage
    p_byp_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (byp_shift && !byp_cap) |=> st_q.byp == $past(tdi));
endmodule

// File: rtl/octal_scan_latch.sv
`timescale 1ns/1ps
module octal_scan_latch
    import bscan_pkg::*;
#(
    parameter int              N_CH      = 8,
    parameter logic [N_CH-1:0] LFSR_TAPS = 8'hB8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            test_mode_i,
    input  logic [1:0]      dr_sel_i,
    input  logic            capture_i,
    input  logic            shift_i,
    input  logic            update_i,
    input  logic            idle_i,
    input  logic            tdi_i,
    output logic            tdo_o,
    input  logic [N_CH-1:0] d_i,
    input  logic            oe_n_i,
    input  logic            le_i,
    output logic [N_CH-1:0] q_o,
    output logic            q_drive_o
);
    typedef struct packed {
        logic [N_CH-1:0] lat;
    } lat_st_t;

    lat_st_t         lat_d, lat_q;
    dr_sel_e         sel;
    bist_code_e      code;
    logic [1:0]      code_raw;
    logic            sel_bsr, sel_bcr, sel_byp;
    logic            bist_run, psa_mode;
    logic            bsr_lsb, bcr_lsb, byp_bit;
    logic [N_CH-1:0] q_hold, q_norm;
    logic            oe_hold;

    assign sel      = dr_sel_e'(dr_sel_i);
    assign code     = bist_code_e'(code_raw);
    assign sel_bsr  = (sel == DR_BOUND);
    assign sel_bcr  = (sel == DR_CTRL);
    assign sel_byp  = !sel_bsr && !sel_bcr;
    assign psa_mode = (code == BIST_PSA);
    assign bist_run = idle_i && (psa_mode || code == BIST_PRPG);

    // functional latch: transparent while le_i is high
    always_comb begin
        lat_d = lat_q;
        if (le_i) begin
            lat_d.lat = d_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign q_norm    = le_i ? d_i : lat_q.lat;
    assign q_o       = test_mode_i ? q_hold : q_norm;
    assign q_drive_o = test_mode_i ? !oe_hold : !oe_n_i;

    bscan_bsr #(.N(N_CH), .TAPS(LFSR_TAPS)) u_bsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (sel_bsr && capture_i),
        .shift_en (sel_bsr && shift_i),
        .upd_en   (sel_bsr && update_i),
        .bist_run (bist_run),
        .psa_mode (psa_mode),
        .tdi      (tdi_i),
        .pin_d    (d_i),
        .pin_oe_n (oe_n_i),
        .pin_le   (le_i),
        .pin_q    (q_o),
        .scan_lsb (bsr_lsb),
        .q_hold_o (q_hold),
        .oe_hold_o(oe_hold)
    );

    bscan_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .bcr_cap  (sel_bcr && capture_i),
        .bcr_shift(sel_bcr && shift_i),
        .bcr_upd  (sel_bcr && update_i),
        .byp_cap  (sel_byp && capture_i),
        .byp_shift(sel_byp && shift_i),
        .tdi      (tdi_i),
        .code_o   (code_raw),
        .bcr_lsb  (bcr_lsb),
        .byp_o    (byp_bit)
    );

    always_comb begin
        case (sel)
            DR_BOUND: tdo_o = bsr_lsb;
            DR_CTRL:  tdo_o = bcr_lsb;
            default:  tdo_o = byp_bit;
        endcase
    end

    // R1: normal-mode disable wins regardless of latch activity
    p_hiz_normal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_mode_i && oe_n_i) |-> !q_drive_o);

    // R2: transparent path
    p_transparent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_mode_i && le_i) |-> q_o == d_i);

    // R2, R11: a closed latch keeps its outputs across cycles
    p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_mode_i && !le_i && !$past(le_i) && !$past(test_mode_i)) |-> $stable(q_o));
endmodule

// File: tb/octal_scan_latch_test.sv
`timescale 1ns/1ps
module octal_scan_latch_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       test_mode = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       cap = 1'b0, sh = 1'b0, upd = 1'b0, idle = 1'b0, tdi = 1'b0;
    logic [7:0] d = 8'h00;
    logic       oe_n = 1'b1, le = 1'b0;
    logic       tdo, drv;
    logic [7:0] q;

    always #2 clk = ~clk;

    octal_scan_latch uut (
        .clk(clk), .rst_n(rst_n), .test_mode_i(test_mode), .dr_sel_i(sel),
        .capture_i(cap), .shift_i(sh), .update_i(upd), .idle_i(idle),
        .tdi_i(tdi), .tdo_o(tdo), .d_i(d), .oe_n_i(oe_n), .le_i(le),
        .q_o(q), .q_drive_o(drv)
    );

    int    checks = 0;
    int    errors = 0;
    string tag = "R12";

    // reference state, bit 0 nearest tdo
    logic [7:0]  m_lat;
    logic [17:0] m_bsr, m_hold;
    logic [1:0]  m_bsh, m_code;
    logic        m_byp;

    task automatic model_reset();
        m_lat = 8'h00; m_bsr = '0; m_hold = 18'h00100;
        m_bsh = 2'b00; m_code = 2'b10; m_byp = 1'b0;
    endtask

    function automatic logic [7:0] exp_q();
        if (test_mode) return m_hold[17:10];
        return le ? d : m_lat;
    endfunction

    function automatic logic exp_drv();
        if (test_mode) return !m_hold[8];
        return !oe_n;
    endfunction

    function automatic logic exp_tdo();
        if (sel == 2'b01) return m_bsr[0];
        if (sel == 2'b10) return m_bsh[0];
        return m_byp;
    endfunction

    function automatic logic [7:0] step8(logic [7:0] s);
        logic fb;
        fb = s[7] ^ s[5] ^ s[4] ^ s[3];
        return {s[6:0], fb};
    endfunction

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_step();
        logic [17:0] nb, nh;
        logic [1:0]  nbs, nc;
        logic        nby;
        logic [7:0]  nl;
        if (!rst_n) begin
            model_reset();
            return;
        end
        nb = m_bsr; nh = m_hold; nbs = m_bsh; nc = m_code; nby = m_byp; nl = m_lat;
        if (le) nl = d;
        if (sel == 2'b01) begin
            if (cap) nb = {exp_q(), le, oe_n, d};
            else if (sh) nb = {tdi, m_bsr[17:1]};
            if (upd) nh = m_bsr;
        end else if (sel == 2'b10) begin
            if (cap) nbs = m_code;
            else if (sh) nbs = {tdi, m_bsh[1]};
            if (upd) nc = m_bsh;
        end else begin
            if (cap) nby = 1'b0;
            else if (sh) nby = tdi;
        end
        if (idle && !(upd && sel == 2'b01)) begin
            if (m_code == 2'b10) nh[17:10] = step8(m_hold[17:10]) ^ d;
            else if (m_code == 2'b01) nh[17:10] = step8(m_hold[17:10]);
        end
        m_bsr = nb; m_hold = nh; m_bsh = nbs; m_code = nc; m_byp = nby; m_lat = nl;
    endtask

    // compare away from the edge, then advance the model with the DUT
    task automatic tick();
        #1;
        check("q_o", {24'h0, q}, {24'h0, exp_q()});
        check("q_drive_o", {31'h0, drv}, {31'h0, exp_drv()});
        check("tdo_o", {31'h0, tdo}, {31'h0, exp_tdo()});
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic scan(logic [1:0] s, logic [31:0] bits, int n, bit do_upd);
        sel = s;
        cap = 1'b1; tick(); cap = 1'b0;
        sh = 1'b1;
        for (int i = 0; i < n; i++) begin
            tdi = bits[i];
            tick();
        end
        sh = 1'b0; tdi = 1'b0;
        if (do_upd) begin
            upd = 1'b1; tick(); upd = 1'b0;
        end
    endtask

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL R12 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_reset();
        @(negedge clk);
        // R12: reset state, then read the control code out
        tag = "R12";
        tick(); tick();
        rst_n = 1'b1;
        tick();
        test_mode = 1'b1; tick();
        check("R12 outputs disabled after reset", {31'h0, drv}, 32'h0);
        test_mode = 1'b0;
        scan(2'b10, 32'h2, 2, 1'b0);

        // R1: enable follows oe_n in normal mode
        tag = "R1";
        oe_n = 1'b1; tick();
        oe_n = 1'b0; tick();
        oe_n = 1'b1; le = 1'b1; d = 8'h11; tick();
        oe_n = 1'b0; tick();

        // R2: transparency and hold
        tag = "R2";
        d = 8'hA5; tick();
        d = 8'h3C; tick();
        le = 1'b0; d = 8'hFF; tick(); tick();
        d = 8'h01; tick();
        check("R2 held value", {24'h0, q}, 32'h3C);
        le = 1'b1; tick();
        le = 1'b0; d = 8'h96; tick();

        // R3: sample pins then shift them out on tdo
        tag = "R3";
        scan(2'b01, 32'h0, 18, 1'b0);

        // R4: shift a known pattern in and update it
        tag = "R4";
        scan(2'b01, 32'h2A5C3, 18, 1'b1);

        // R11: test activity in normal mode leaves pins alone
        tag = "R11";
        idle = 1'b1;
        for (int i = 0; i < 5; i++) begin d = 8'h40 + 8'(i); tick(); end
        idle = 1'b0;
        scan(2'b01, 32'h3FFFF, 18, 1'b1);
        scan(2'b10, 32'h2, 2, 1'b1);

        // R5: hold stage drives the pins in test mode
        tag = "R5";
        test_mode = 1'b1; tick();
        scan(2'b01, 32'h16800, 18, 1'b1);
        check("R5 driven pattern", {24'h0, q}, 32'h5A);
        check("R5 driven enable", {31'h0, drv}, 32'h1);
        scan(2'b01, 32'h16900, 18, 1'b1);
        check("R5 disabled enable", {31'h0, drv}, 32'h0);
        scan(2'b01, 32'h16800, 18, 1'b1);

        // R6: load pattern mode code
        tag = "R6";
        scan(2'b10, 32'h1, 2, 1'b1);
        scan(2'b10, 32'h1, 2, 1'b0);

        // R9: pattern generation from the 5A seed, then no-op codes
        tag = "R9";
        idle = 1'b1;
        for (int i = 0; i < 10; i++) tick();
        idle = 1'b0;
        scan(2'b10, 32'h3, 2, 1'b1);
        idle = 1'b1;
        for (int i = 0; i < 4; i++) begin d = 8'h0F ^ 8'(i); tick(); end
        idle = 1'b0;
        scan(2'b10, 32'h0, 2, 1'b1);
        idle = 1'b1; tick(); tick(); idle = 1'b0;

        // R8: signature with changing inputs
        tag = "R8";
        scan(2'b10, 32'h2, 2, 1'b1);
        idle = 1'b1;
        for (int i = 0; i < 8; i++) begin d = 8'(i * 37 + 5); tick(); end
        idle = 1'b0;

        // R10: no steps outside idle
        tag = "R10";
        for (int i = 0; i < 4; i++) begin d = 8'hC3 ^ 8'(i); tick(); end

        // R7: bypass via both select codes
        tag = "R7";
        scan(2'b00, 32'h0B, 6, 1'b0);
        scan(2'b11, 32'h05, 4, 1'b0);
        tick();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule